// File: doc/BRIEF.md
# Priority Reference Clock Selector

This block picks one of several reference clock inputs for a timing path. For every input it receives a validity flag and a 4-bit priority code. An input counts as a candidate only when it is valid and its code is nonzero. In automatic mode the block keeps the best candidate selected. Revertive operation moves to a better candidate as soon as one appears. Non-revertive operation holds the present input for as long as that input remains a candidate. Forced mode and external fast mode take the index straight from an input port and ignore qualification.

The same module serves two paths, chosen with the `IS_MAIN` parameter. The main path supports all modes. The secondary path always switches revertively and treats the external mode as automatic. It also has one control bit that locks it to the main path's output instead of to any input. While that bit is set, nothing else changes its selection. Qualification, priorities and controls are registered once, and the selection is evaluated again on every cycle. Outputs are the selected index, a lock-to-main flag, a "no candidate" flag and a one-cycle switch pulse.

Top module: `ref_selector`

## Requirements
- R1: An input is a candidate only when its `valid_i` bit is 1 and its priority field `prio_i[n*4 +: 4]` is nonzero. Code 0000 excludes a valid input from automatic selection.
- R2: A lower nonzero code means a higher priority (1 is best, 15 is worst). Automatic selection takes the candidate with the lowest code. When codes are equal, the lowest index wins.
- R3: In revertive automatic mode the selection moves to the best candidate when the present input stops being a candidate, or when another candidate has a strictly lower code. A candidate with an equal code causes no switch.
- R4: On the main path with `revertive_i`=0, automatic mode keeps the present input while it remains a candidate, and moves to the best candidate only when it stops being one.
- R5: In automatic mode with no candidate, the index is held and `none_o` is 1. In every other case `none_o` is 0.
- R6: With `mode_i`=01 (forced), the index becomes `force_idx_i` whether or not that input is a candidate. A forced index of N_IN or above leaves the index unchanged.
- R7: With `mode_i`=10 (external fast), the main path takes `ext_idx_i`, and indices of N_IN or above are ignored. On the secondary path `mode_i`=10 acts as automatic. `mode_i`=00 and 11 are automatic.
- R8: The secondary path always behaves revertively, whatever the value of `revertive_i`.
- R9: On the secondary path, `use_main_i`=1 sets `sel_main_o` and freezes the index in every mode. Clearing it resumes normal selection. The main path ignores `use_main_i`.
- R10: `switch_o` is 1 for exactly the cycles in which the index or `sel_main_o` takes a new value.
- R11: A change at the inputs reaches the outputs at the second rising edge. After reset the outputs are: index 0, `none_o`=1, `switch_o`=0, `sel_main_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | N_IN | Validity flag per input |
| prio_i | input | N_IN*PW | Priority code per input; input n at bits [n*PW +: PW] |
| mode_i | input | 2 | 00/11 automatic, 01 forced, 10 external fast |
| revertive_i | input | 1 | Main path: 1 revertive, 0 non-revertive |
| force_idx_i | input | IW | Index used in forced mode |
| ext_idx_i | input | IW | Index used in external fast mode |
| use_main_i | input | 1 | Secondary path: lock to the main path output |
| sel_idx_o | output | IW | Selected input index |
| sel_main_o | output | 1 | Secondary path is locked to the main path |
| none_o | output | 1 | No candidate available in automatic mode |
| switch_o | output | 1 | One-cycle pulse when the selection changes |

## Verification
The bench builds two copies with the default five inputs and 4-bit codes: one with `IS_MAIN`=1 and one with `IS_MAIN`=0. Both copies receive identical stimulus. Every scenario therefore shows the main and secondary behaviour side by side: non-revertive holding against forced reversion, external fast against automatic, and an ignored against an honoured lock bit. With five inputs, the 3-bit index can encode the out-of-range values 5 to 7, so the bench can exercise the rule that ignores forced and external indices in that range.

// File: rtl/ref_selector.sv
module ref_selector #(
  parameter int N_IN    = 5,
  parameter int PW      = 4,
  parameter bit IS_MAIN = 1'b1,
  localparam int IW     = $clog2(N_IN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    valid_i,
  input  logic [N_IN*PW-1:0] prio_i,
  input  logic [1:0]         mode_i,
  input  logic               revertive_i,
  input  logic [IW-1:0]      force_idx_i,
  input  logic [IW-1:0]      ext_idx_i,
  input  logic               use_main_i,
  output logic [IW-1:0]      sel_idx_o,
  output logic               sel_main_o,
  output logic               none_o,
  output logic               switch_o
);
  localparam logic [1:0]  MODE_FORCE = 2'b01;
  localparam logic [1:0]  MODE_EXT   = 2'b10;
  localparam logic [IW:0] IDX_LIM    = N_IN[IW:0];

  logic [N_IN-1:0] qual_r;
  logic [PW-1:0]   prio_r [N_IN];
  logic [1:0]      mode_r;
  logic            rev_r, lock_r;
  logic [IW-1:0]   force_r, ext_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_r  <= '0;
      mode_r  <= '0;
      rev_r   <= 1'b1;
      lock_r  <= 1'b0;
      force_r <= '0;
      ext_r   <= '0;
      for (int i = 0; i < N_IN; i++) prio_r[i] <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        qual_r[i] <= valid_i[i] && (prio_i[i*PW +: PW] != '0);
        prio_r[i] <= prio_i[i*PW +: PW];
      end
      mode_r  <= mode_i;
      rev_r   <= revertive_i;
      lock_r  <= use_main_i;
      force_r <= force_idx_i;
      ext_r   <= ext_idx_i;
    end
  end

  logic          any_q;
  logic [IW-1:0] best;
  logic [PW-1:0] best_p;

  always_comb begin
    any_q  = 1'b0;
    best   = '0;
    best_p = '1;
    for (int i = 0; i < N_IN; i++) begin
      if (qual_r[i] && (!any_q || prio_r[i] < best_p)) begin
        any_q  = 1'b1;
        best   = IW'(i);
        best_p = prio_r[i];
      end
    end
  end

  logic [IW-1:0] sel_r, nxt_sel;
  logic          nxt_none;
  wire lock_eff = !IS_MAIN && lock_r;
  wire ext_eff  = IS_MAIN && (mode_r == MODE_EXT);
  wire rev_eff  = !IS_MAIN || rev_r;
  wire cur_ok   = qual_r[sel_r];

  always_comb begin
    nxt_sel  = sel_r;
    nxt_none = 1'b0;
    if (lock_eff) begin
      nxt_sel = sel_r;
    end else if (mode_r == MODE_FORCE) begin
      if ({1'b0, force_r} < IDX_LIM) nxt_sel = force_r;
    end else if (ext_eff) begin
      if ({1'b0, ext_r} < IDX_LIM) nxt_sel = ext_r;
    end else if (!any_q) begin
      nxt_none = 1'b1;
    end else if (!cur_ok) begin
      nxt_sel = best;
    end else if (rev_eff && best_p < prio_r[sel_r]) begin
      nxt_sel = best;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r      <= '0;
      sel_main_o <= 1'b0;
      none_o     <= 1'b1;
      switch_o   <= 1'b0;
    end else begin
      sel_r      <= nxt_sel;
      sel_main_o <= lock_eff;
      none_o     <= nxt_none;
      switch_o   <= (nxt_sel != sel_r) || (lock_eff != sel_main_o);
    end
  end

  assign sel_idx_o = sel_r;
endmodule

module ref_selector_chk #(
  parameter int N_IN = 5,
  parameter int IW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          use_main_i,
  input logic [IW-1:0] sel_idx_o,
  input logic          sel_main_o,
  input logic          none_o,
  input logic          switch_o
);
  p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_idx_o) < N_IN);

  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (sel_idx_o != $past(sel_idx_o)) || (sel_main_o != $past(sel_main_o)));

  p_quiet_when_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_o |-> $stable(sel_idx_o) && $stable(sel_main_o));

  p_none_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> $stable(sel_idx_o));

  p_lock_follows_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_main_o |-> $past(use_main_i, 2));

  p_lock_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_main_o |-> $stable(sel_idx_o));
endmodule

bind ref_selector ref_selector_chk #(.N_IN(N_IN), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .use_main_i(use_main_i), .sel_idx_o(sel_idx_o),
  .sel_main_o(sel_main_o), .none_o(none_o), .switch_o(switch_o)
);

// File: tb/ref_selector_bench.sv
module ref_selector_bench;
  localparam int N  = 5;
  localparam int PW = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  valid = '0;
  logic [N*PW-1:0] prio = '0;
  logic [1:0]    mode = 2'b00;
  logic          rev = 1'b1;
  logic [IW-1:0] fidx = '0, eidx = '0;
  logic          use_main = 1'b0;
  logic [IW-1:0] m_idx, s_idx;
  logic          m_main, s_main, m_none, s_none, m_sw, s_sw;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ref_selector #(.N_IN(N), .PW(PW), .IS_MAIN(1'b1)) u_ref_selector (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .prio_i(prio), .mode_i(mode),
    .revertive_i(rev), .force_idx_i(fidx), .ext_idx_i(eidx), .use_main_i(use_main),
    .sel_idx_o(m_idx), .sel_main_o(m_main), .none_o(m_none), .switch_o(m_sw));

  ref_selector #(.N_IN(N), .PW(PW), .IS_MAIN(1'b0)) u_ref_selector_sec (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .prio_i(prio), .mode_i(mode),
    .revertive_i(rev), .force_idx_i(fidx), .ext_idx_i(eidx), .use_main_i(use_main),
    .sel_idx_o(s_idx), .sel_main_o(s_main), .none_o(s_none), .switch_o(s_sw));

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_prio(input int n, input logic [PW-1:0] v);
    prio[n*PW +: PW] = v;
  endtask

  task automatic expect_both(input string tag, input int mi, input int mn, input int msw,
                             input int si, input int sn, input int ssw);
    check({tag, " main idx"}, m_idx, mi);
    check({tag, " main none"}, m_none, mn);
    check({tag, " main switch"}, m_sw, msw);
    check({tag, " sec idx"}, s_idx, si);
    check({tag, " sec none"}, s_none, sn);
    check({tag, " sec switch"}, s_sw, ssw);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_both("R11 reset", 0, 1, 0, 0, 1, 0);
    check("R11 reset main lock", m_main, 0);
    check("R11 reset sec lock", s_main, 0);
  endtask

  task automatic t_zero_code();
    valid = '1;
    step();
    expect_both("R1 zero codes excluded", 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_pick_best();
    set_prio(0, 5); set_prio(1, 3); set_prio(2, 3); set_prio(3, 7); set_prio(4, 0);
    @(posedge clk);
    @(negedge clk);
    check("R11 no change after one edge", m_idx, 0);
    @(posedge clk);
    @(negedge clk);
    expect_both("R2 lowest code, lowest index", 1, 0, 1, 1, 0, 1);
    @(negedge clk);
    check("R10 pulse lasts one cycle main", m_sw, 0);
    check("R10 pulse lasts one cycle sec", s_sw, 0);
  endtask

  task automatic t_revertive();
    set_prio(3, 3);
    step();
    expect_both("R3 equal code no switch", 1, 0, 0, 1, 0, 0);
    set_prio(4, 2);
    step();
    expect_both("R3 better code switches", 4, 0, 1, 4, 0, 1);
  endtask

  task automatic t_nonrevertive();
    rev = 1'b0;
    set_prio(0, 1);
    step();
    expect_both("R4 R8 non-revertive hold vs sec revert", 4, 0, 0, 0, 0, 1);
    valid[4] = 1'b0;
    step();
    expect_both("R4 current lost moves to best", 0, 0, 1, 0, 0, 0);
    rev = 1'b1;
  endtask

  task automatic t_none();
    valid = '0;
    step();
    expect_both("R5 no candidate holds", 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_forced();
    mode = 2'b01; fidx = 3'd3;
    step();
    expect_both("R6 forced ignores qualification", 3, 0, 1, 3, 0, 1);
    fidx = 3'd7;
    step();
    expect_both("R6 forced out of range ignored", 3, 0, 0, 3, 0, 0);
  endtask

  task automatic t_external();
    mode = 2'b10; eidx = 3'd2;
    step();
    expect_both("R7 external main, auto sec", 2, 0, 1, 3, 1, 0);
    eidx = 3'd5;
    step();
    check("R7 external out of range ignored", m_idx, 2);
  endtask

  task automatic t_lock();
    mode = 2'b01; fidx = 3'd1; use_main = 1'b1;
    step();
    expect_both("R9 lock on sec, ignored on main", 1, 0, 1, 3, 0, 1);
    check("R9 sec lock flag", s_main, 1);
    check("R9 main lock flag ignored", m_main, 0);
    fidx = 3'd4;
    step();
    check("R9 locked sec index frozen", s_idx, 3);
    check("R9 locked sec no switch", s_sw, 0);
    use_main = 1'b0;
    step();
    check("R9 release resumes forced", s_idx, 4);
    check("R9 release clears flag", s_main, 0);
    check("R10 release pulse", s_sw, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_code();
    t_pick_best();
    t_revertive();
    t_nonrevertive();
    t_none();
    t_forced();
    t_external();
    t_lock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule